// File: doc/BRIEF.md
# Buffer-Fill Adaptive Playout Clock

This block regenerates a steady output word rate for a constant-rate TDM stream that reaches the receiver in packets with random transit delay. Each arriving payload word is pushed into a small jitter buffer. Words are pulled out at the carry rate of a 32-bit phase-accumulator oscillator. The oscillator's increment is a fixed nominal value plus a signed correction.

The correction comes from a slow control loop that watches how full the buffer is. At a fixed number of read strobes the loop takes a sample of the fill level. A first-order recursive average of these samples is kept with fractional bits, so the loop sees a smoothed level that is finer than one word. A proportional-plus-integral filter then turns the distance between that smoothed level and the buffer midpoint into the correction. A buffer that fills up on average therefore speeds up reading, and a buffer that drains on average slows it down. The loop also pulls the level back toward the midpoint, so it does not drift toward either end of the buffer.

Reading starts only after the buffer has first reached half full. If a read finds the buffer empty, a fixed idle word goes out. A write that finds the buffer full is discarded. Both events set sticky flags, and both also clear the lock indication.

Top module: `fill_steered_playout`

## Requirements
- R1: While reset is asserted and directly after it, `rd_strobe`, `locked`, `ovf_flag` and `udf_flag` are 0 and `rd_data` is 0.
- R2: No read strobe occurs until the fill level has reached DEPTH/2 = 16 words. The first strobe comes only after at least 16 words have been written.
- R3: A read event occurs in each cycle where the 32-bit accumulator (phase + NOM_INC + correction) carries. `rd_strobe` is high one cycle later. Before the first loop update the correction is 0, so with NOM_INC = 2^29 strobes are exactly 8 cycles apart.
- R4: Words leave in the order they were accepted. `rd_data` is valid in the cycle `rd_strobe` is high.
- R5: A read event that finds the buffer empty outputs IDLE_WORD (all ones) and sets `udf_flag`.
- R6: A write that finds the buffer full (32 words) is dropped, even if a read frees a slot in the same cycle, and it sets `ovf_flag`.
- R7: `ovf_flag` and `udf_flag` stay set until `clr_flags` is high. A new event in the same cycle as `clr_flags` keeps the flag set.
- R8: On every SAMPLE_DIV-th read event (8), the smoothed level takes a step of (fill*2^8 - avg) >>> 3. The level has 8 fractional bits and starts at 16*2^8.
- R9: On the cycle after a sample, the error e = avg - 16*2^8 updates the integrator to I = clip(I + e*2^9). The correction becomes clip(e*2^14 + I), where clip limits values to ±2^26. A level above the midpoint therefore raises the read rate.
- R10: `locked` rises after 16 consecutive updates with |e| < 2560. It falls on an update with |e| >= 2560, and on any overflow or underflow event.
- R11: The fill level changes by at most one word per cycle. A write and a read in the same cycle leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A payload word is offered this cycle |
| wr_data | input | DW | Payload word |
| clr_flags | input | 1 | Clears both sticky event flags |
| rd_strobe | output | 1 | One-cycle pulse per played-out word |
| rd_data | output | DW | Played-out word, or IDLE_WORD on underflow |
| locked | output | 1 | Loop is settled near the buffer midpoint |
| ovf_flag | output | 1 | Sticky: a write was dropped on a full buffer |
| udf_flag | output | 1 | Sticky: a read found the buffer empty |

## Verification
The write port and the oscillator-driven read can act in the same cycle at either edge of the buffer.

A write can arrive at a full buffer while a read strobe fires. That write must still be dropped, and the level must stay at 32. A write can also arrive at an empty buffer while a read fires. In that case the idle word goes out and the new word is kept for the next read.

The bench provokes both cases with a burst phase of back-to-back writes and with a silent phase. Each case runs while the oscillator keeps firing at its steered rate. A behavioural queue model judges every cycle's strobe, data, lock and flags.

// File: rtl/fill_steered_playout.sv
module fill_steered_playout #(
  parameter int DW = 8,
  parameter int AW = 5,
  parameter int FR = 8,
  parameter logic [31:0] NOM_INC = 32'h2000_0000,
  parameter int AVG_SH = 3,
  parameter int SAMPLE_DIV = 8,
  parameter int KP_SH = 14,
  parameter int KI_SH = 9,
  parameter int CORR_LIM = 67108864,
  parameter int LOCK_THR = 2560,
  parameter int LOCK_CNT = 16,
  parameter logic [DW-1:0] IDLE_WORD = {DW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          clr_flags,
  output logic          rd_strobe,
  output logic [DW-1:0] rd_data,
  output logic          locked,
  output logic          ovf_flag,
  output logic          udf_flag
);
  localparam int DEPTH = 1 << AW;
  localparam int CENTER = DEPTH / 2;
  localparam int LW = AW + 1;
  localparam int AVW = LW + FR;
  localparam int EW = AVW + 1;
  localparam int SCW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam int LCW = $clog2(LOCK_CNT + 1);
  localparam logic signed [63:0] LIM = 64'(CORR_LIM);
  localparam logic signed [EW-1:0] SETPT = EW'(CENTER << FR);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [LW-1:0] fill;
  logic running, upd;
  logic [31:0] phase;
  logic signed [31:0] corr, integ;
  logic [AVW-1:0] avg;
  logic [SCW-1:0] scnt;
  logic [LCW-1:0] lcnt;

  function automatic logic signed [31:0] clip(input logic signed [63:0] v);
    if (v > LIM) return 32'(LIM);
    if (v < -LIM) return 32'(-LIM);
    return 32'(v);
  endfunction

  // oscillator and buffer events
  logic [31:0] inc;
  logic [32:0] nco_sum;
  logic tick, full, empty, wr_ok, rd_ok, ovf_ev, udf_ev, samp;
  assign inc     = NOM_INC + $unsigned(corr);
  assign nco_sum = {1'b0, phase} + {1'b0, inc};
  assign tick    = running & nco_sum[32];
  assign full    = (fill == LW'(DEPTH));
  assign empty   = (fill == '0);
  assign wr_ok   = wr_valid & ~full;
  assign ovf_ev  = wr_valid & full;
  assign rd_ok   = tick & ~empty;
  assign udf_ev  = tick & empty;
  assign samp    = tick & (scnt == SCW'(SAMPLE_DIV - 1));

  // fill averaging
  logic signed [AVW+1:0] diff, step;
  logic [AVW-1:0] avg_next;
  assign diff     = $signed({2'b00, fill, {FR{1'b0}}}) - $signed({2'b00, avg});
  assign step     = diff >>> AVG_SH;
  assign avg_next = avg + AVW'(step);

  // loop filter
  logic signed [EW-1:0] err;
  logic [EW-1:0] err_mag;
  logic signed [31:0] i_new, c_new;
  assign err     = $signed({1'b0, avg}) - SETPT;
  assign err_mag = err[EW-1] ? EW'(-err) : EW'(err);
  assign i_new   = clip(longint'(integ) + (longint'(err) <<< KI_SH));
  assign c_new   = clip((longint'(err) <<< KP_SH) + longint'(i_new));

  always_ff @(posedge clk)
    if (wr_ok) mem[wp] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
      running <= 1'b0; upd <= 1'b0; phase <= '0;
      corr <= '0; integ <= '0; avg <= AVW'(CENTER << FR);
      scnt <= '0; lcnt <= '0; locked <= 1'b0;
      rd_strobe <= 1'b0; rd_data <= '0;
      ovf_flag <= 1'b0; udf_flag <= 1'b0;
    end else begin
      if (wr_ok) wp <= wp + 1'b1;
      if (rd_ok) rp <= rp + 1'b1;
      fill <= fill + LW'(wr_ok) - LW'(rd_ok);
      if (!running && fill >= LW'(CENTER)) running <= 1'b1;
      phase <= running ? nco_sum[31:0] : 32'd0;
      rd_strobe <= tick;
      if (tick) rd_data <= empty ? IDLE_WORD : mem[rp];
      if (tick) scnt <= samp ? '0 : scnt + 1'b1;
      if (samp) avg <= avg_next;
      upd <= samp;
      if (upd) begin
        integ <= i_new;
        corr  <= c_new;
      end
      if (ovf_ev | udf_ev) begin
        lcnt <= '0; locked <= 1'b0;
      end else if (upd) begin
        if (err_mag < EW'(LOCK_THR)) begin
          if (lcnt != LCW'(LOCK_CNT)) lcnt <= lcnt + 1'b1;
          if (lcnt >= LCW'(LOCK_CNT - 1)) locked <= 1'b1;
        end else begin
          lcnt <= '0; locked <= 1'b0;
        end
      end
      ovf_flag <= ovf_ev | (ovf_flag & ~clr_flags);
      udf_flag <= udf_ev | (udf_flag & ~clr_flags);
    end
  end

  a_r2_start_at_half: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> int'($past(fill)) >= CENTER);
  a_r5_idle_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && $past(empty)) |-> rd_data == IDLE_WORD);
  a_r6_drop_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_ev |=> int'(fill) <= int'($past(fill)));
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_flags) |=> ovf_flag);
  a_r7_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (udf_flag && !clr_flags) |=> udf_flag);
  a_r9_corr_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (corr <= CORR_LIM) && (corr >= -CORR_LIM));
  a_r10_unlock_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_ev || udf_ev) |=> !locked);
  a_r11_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill) <= int'($past(fill)) + 1) && (int'(fill) + 1 >= int'($past(fill))));
endmodule

// File: tb/fill_steered_playout_tb_top.sv
module fill_steered_playout_tb_top;
  localparam int DEPTH = 32;
  localparam int CENTER = 16;
  localparam longint NOM = 64'h2000_0000;
  localparam longint LIM = 67108864;
  localparam logic [7:0] IDLE = 8'hFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic clr_flags = 1'b0;
  logic rd_strobe, locked, ovf_flag, udf_flag;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  fill_steered_playout dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .clr_flags(clr_flags), .rd_strobe(rd_strobe), .rd_data(rd_data),
    .locked(locked), .ovf_flag(ovf_flag), .udf_flag(udf_flag));

  // behavioural reference
  logic [7:0] q[$];
  longint m_phase, m_corr, m_integ, m_avg;
  int m_scnt, m_lcnt;
  bit m_run, m_upd, m_lock, m_strobe, m_ovf, m_udf;
  logic [7:0] m_data;

  function automatic longint clip(longint v);
    if (v > LIM) return LIM;
    if (v < -LIM) return -LIM;
    return v;
  endfunction

  always @(posedge clk) begin : ref_model
    int fill;
    longint sum, err, inew;
    bit tick, full, empty, ovf_ev, udf_ev, samp;
    if (!rst_n) begin
      q.delete();
      m_phase = 0; m_corr = 0; m_integ = 0; m_avg = CENTER * 256;
      m_scnt = 0; m_lcnt = 0; m_run = 0; m_upd = 0; m_lock = 0;
      m_strobe = 0; m_ovf = 0; m_udf = 0; m_data = 8'h00;
    end else begin
      fill = q.size();
      sum = m_phase + NOM + m_corr;
      tick = m_run && (sum >= 64'h1_0000_0000);
      full = (fill == DEPTH);
      empty = (fill == 0);
      ovf_ev = wr_valid && full;
      udf_ev = tick && empty;
      samp = tick && (m_scnt == 7);
      err = m_avg - CENTER * 256;
      if (ovf_ev || udf_ev) begin
        m_lcnt = 0; m_lock = 0;
      end else if (m_upd) begin
        if ((err < 0 ? -err : err) < 2560) begin
          if (m_lcnt >= 15) m_lock = 1;
          if (m_lcnt != 16) m_lcnt++;
        end else begin
          m_lcnt = 0; m_lock = 0;
        end
      end
      if (m_upd) begin
        inew = clip(m_integ + err * 512);
        m_corr = clip(err * 16384 + inew);
        m_integ = inew;
      end
      m_strobe = tick;
      if (tick) m_data = empty ? IDLE : q.pop_front();
      if (wr_valid && !full) q.push_back(wr_data);
      if (samp) m_avg = m_avg + ((longint'(fill) * 256 - m_avg) >>> 3);
      m_upd = samp;
      if (tick) m_scnt = samp ? 0 : m_scnt + 1;
      m_phase = m_run ? (sum & 64'hFFFF_FFFF) : 0;
      if (fill >= CENTER) m_run = 1;
      m_ovf = ovf_ev || (m_ovf && !clr_flags);
      m_udf = udf_ev || (m_udf && !clr_flags);
    end
  end

  int n_chk = 0, n_fail = 0;
  int cyc_n = 0, n_wr = 0, first_rd = -1, second_rd = -1, strobes = 0;
  int mode = 0, period = 64, slot_pos = 0, jit_off = 0, pending = 0;
  bit seen_lock = 0, seen_idle = 0, done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cyc_n++;
    check(rd_strobe == m_strobe, "R3 R8 R9 strobe", rd_strobe, m_strobe);
    if (m_strobe) check(rd_data == m_data, "R4 R5 R11 data", rd_data, m_data);
    check(locked == m_lock, "R10 lock", locked, m_lock);
    check(ovf_flag == m_ovf, "R6 R7 ovf", ovf_flag, m_ovf);
    check(udf_flag == m_udf, "R5 R7 udf", udf_flag, m_udf);
    if (rd_strobe) begin
      strobes++;
      if (rd_data == IDLE) seen_idle = 1;
      if (first_rd < 0) begin
        first_rd = cyc_n;
        check(n_wr >= CENTER, "R2 holdoff", n_wr, CENTER);
      end else if (second_rd < 0) second_rd = cyc_n;
    end
    if (locked) seen_lock = 1;
    // next inputs
    clr_flags = 1'b0;
    if (mode == 1) begin
      if (slot_pos == jit_off) pending += 8;
      slot_pos++;
      if (slot_pos == period) begin
        slot_pos = 0;
        jit_off = $urandom_range(0, 20);
      end
    end
    wr_valid = 1'b0;
    if (mode == 2) wr_valid = 1'b1;
    else if (pending > 0 && mode != 0) begin
      wr_valid = 1'b1;
      pending--;
    end
    if (wr_valid) begin
      wr_data = wr_data + 8'd1;
      n_wr++;
    end
  endtask

  initial begin : stim
    int base;
    repeat (3) cyc();
    check(rd_strobe == 0 && locked == 0 && ovf_flag == 0 && udf_flag == 0 && rd_data == 0,
          "R1 reset outputs", {rd_strobe, locked, ovf_flag, udf_flag}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // nominal-rate packets with delay jitter
    mode = 1; period = 64;
    repeat (6000) cyc();
    check(second_rd - first_rd == 8, "R3 nominal spacing", second_rd - first_rd, 8);
    check(seen_lock, "R10 lock reached", seen_lock, 1);
    check(!ovf_flag && !udf_flag, "R8 level held near centre", {ovf_flag, udf_flag}, 0);
    // sender slightly fast
    period = 63;
    repeat (4000) cyc();
    base = strobes;
    repeat (6000) cyc();
    check(strobes - base > 750, "R9 rate raised", strobes - base, 751);
    // back-to-back writes overrun the buffer
    mode = 2;
    repeat (60) cyc();
    check(ovf_flag == 1, "R6 overflow flag", ovf_flag, 1);
    check(locked == 0, "R10 unlock on overflow", locked, 0);
    mode = 0; pending = 0;
    cyc();
    clr_flags = 1'b1;
    cyc();
    cyc();
    check(ovf_flag == 0, "R7 flag cleared", ovf_flag, 0);
    // silence drains the buffer
    repeat (800) cyc();
    check(udf_flag == 1, "R5 underflow flag", udf_flag, 1);
    check(seen_idle, "R5 idle word output", seen_idle, 1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", cyc_n, 17000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule